// File: doc/BRIEF.md
# Single-Pin Framed Word Link

This block moves 32-bit words between two devices over one shared pin. A word is wrapped in a short frame. The frame opens with a fixed three-bit start pattern and closes with a single stop bit. The transmitter shifts the frame out at one bit per bit period. The receiver watches the same pin, finds the start pattern and hands over the captured word. The link is half-duplex. A sender posts a word, then waits: the busy flag stays high until the last frame bit has left. A receiver simply waits for the one-clock valid strobe.

The bit period is a whole number of system clocks, set by `CLKS_PER_BIT`. The default of 2 gives 100 Mbit/s from a 200 MHz clock. The transmitter and the receiver share one free-running bit-tick. Each frame bit is sampled once, on a tick, and there is no oversampling. The pin's direction bit comes from outside the block and passes through unchanged. The transmitter reaches the pad only while that bit is high, and traffic seen by the receiver never changes it.

Top module: `pin_msg_link`

## Requirements
- R1: A frame is 36 bits sent in this order: the start pattern 0,1,0, then the 32 payload bits with the most significant bit first, then a stop bit of 0. The line rests at 0 between frames.
- R2: Each frame bit occupies exactly one bit period of `CLKS_PER_BIT` system clocks, and the receiver takes one sample of the pin per bit period.
- R3: A send is accepted on a clock where `send_req` is high and `send_busy` is low. `send_busy` is high from the next clock for 36 bit periods, that is between 35*CLKS_PER_BIT+1 and 36*CLKS_PER_BIT clocks. `send_done` pulses for one clock on the clock where `send_busy` falls.
- R4: A `send_req` raised while `send_busy` is high has no effect. The frame in flight keeps its word, and no second frame follows.
- R5: `pin_dir` always equals `dir_en`. Neither sending nor receiving ever changes it. `pin_out` is 0 whenever `dir_en` is 0, and a send made with `dir_en` low still completes.
- R6: The receiver starts matching only on a 0-to-1 step that follows at least one sampled 0. If the sample after that 1 is not 0, the receiver drops the attempt and hunts again.
- R7: After a stop bit of 0, `rx_valid` is high for exactly one clock, and `rx_word` carries the payload during that clock. At all other times `rx_word` is 0.
- R8: After a stop bit of 1, the frame is dropped: `rx_frame_err` pulses for one clock, `rx_valid` stays low, and the receiver goes back to hunting, so a later good frame is still accepted.
- R9: While reset is high and just after it, `send_busy`, `send_done`, `pin_out`, `rx_valid` and `rx_frame_err` are 0, and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| send_req | input | 1 | Request to send `send_word` |
| send_word | input | 32 | Word to send, taken when the request is accepted |
| send_busy | output | 1 | High while a frame is being sent |
| send_done | output | 1 | One-clock pulse when the frame has finished |
| dir_en | input | 1 | Pin direction bit, 1 means drive |
| pin_dir | output | 1 | Direction to the pad, a copy of `dir_en` |
| pin_out | output | 1 | Data to the pad |
| pin_in | input | 1 | Sampled level of the pad |
| rx_valid | output | 1 | One-clock strobe for a received word |
| rx_word | output | 32 | Received payload while `rx_valid` is high, 0 otherwise |
| rx_frame_err | output | 1 | One-clock pulse when a frame is dropped for a bad stop bit |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 3 instead of the default 2. The wider bit period gives the accept point three possible phases against the tick, which tests both ends of the busy-length window, and it shows that bits are counted in ticks rather than in clocks. The pad is modelled as a shared wire: the block hears its own frames while `dir_en` is high. While `dir_en` is low, the bench drives hand-built frames with good and bad stop bits and false starts. Those frames hold each bit for three clocks at an arbitrary phase against the internal tick.

// File: rtl/pin_msg_pkg.sv
package pin_msg_pkg;

    localparam int PAYLOAD_W = 32;
    localparam int START_W   = 3;
    localparam int FRAME_W   = START_W + PAYLOAD_W + 1;

    localparam logic [START_W-1:0] START_PAT = 3'b010;
    localparam logic               STOP_LVL  = 1'b0;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START_END,
        RX_PAYLOAD,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic                 valid;
        logic                 frame_err;
        logic [PAYLOAD_W-1:0] word;
    } rx_result_t;

    // Frame image, first bit on the wire in the top position.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [PAYLOAD_W-1:0] w);
        return {START_PAT, w, STOP_LVL};
    endfunction

endpackage

// File: rtl/pin_msg_tick.sv
module pin_msg_tick #(
    parameter int CLKS_PER_BIT = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST);

    generate
        if (CLKS_PER_BIT > 1) begin : g_spaced
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pin_msg_tx.sv
module pin_msg_tx
    import pin_msg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 send_req,
    input  logic [PAYLOAD_W-1:0] send_word,
    output logic                 busy,
    output logic                 done,
    output logic                 line_bit
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            shreg <= '0;
            left  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (send_req) begin
                    busy  <= 1'b1;
                    shreg <= build_frame(send_word);
                    left  <= LOAD_CNT;
                end
            end else if (tick) begin
                if (left == '0) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    shreg <= '0;
                end else begin
                    shreg <= shreg << 1;
                    left  <= left - 1'b1;
                end
            end
        end
    end

    assign line_bit = shreg[FRAME_W-1];

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !tick |=> busy);

    // R3
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !tick |=> $stable(shreg));

endmodule

// File: rtl/pin_msg_rx.sv
module pin_msg_rx
    import pin_msg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line_in,
    output rx_result_t result
);
    localparam int CNT_W = $clog2(PAYLOAD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PAYLOAD_W - 1);

    rx_state_e            state;
    logic                 prev;
    logic [PAYLOAD_W-1:0] shift;
    logic [CNT_W-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_HUNT;
            prev   <= 1'b1;
            shift  <= '0;
            cnt    <= '0;
            result <= '0;
        end else begin
            result <= '0;
            if (tick) begin
                prev <= line_in;
                unique case (state)
                    RX_HUNT: begin
                        if (!prev && line_in) state <= RX_START_END;
                    end
                    RX_START_END: begin
                        if (!line_in) begin
                            state <= RX_PAYLOAD;
                            cnt   <= '0;
                        end else begin
                            state <= RX_HUNT;
                        end
                    end
                    RX_PAYLOAD: begin
                        shift <= {shift[PAYLOAD_W-2:0], line_in};
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) state <= RX_STOP;
                    end
                    RX_STOP: begin
                        if (line_in == STOP_LVL) begin
                            result.valid <= 1'b1;
                            result.word  <= shift;
                        end else begin
                            result.frame_err <= 1'b1;
                        end
                        state <= RX_HUNT;
                    end
                    default: state <= RX_HUNT;
                endcase
            end
        end
    end

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        result.valid |=> !result.valid);

    // R8
    err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        result.frame_err |-> !result.valid && state == RX_HUNT);

    // R7
    valid_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        result.valid |-> $past(state) == RX_STOP && state == RX_HUNT);

endmodule

// File: rtl/pin_msg_link.sv
module pin_msg_link
    import pin_msg_pkg::*;
#(
    parameter int CLKS_PER_BIT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        send_req,
    input  logic [31:0] send_word,
    output logic        send_busy,
    output logic        send_done,
    input  logic        dir_en,
    output logic        pin_dir,
    output logic        pin_out,
    input  logic        pin_in,
    output logic        rx_valid,
    output logic [31:0] rx_word,
    output logic        rx_frame_err
);
    logic       tick;
    logic       tx_bit;
    rx_result_t rx_res;

    pin_msg_tick #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pin_msg_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .send_req  (send_req),
        .send_word (send_word),
        .busy      (send_busy),
        .done      (send_done),
        .line_bit  (tx_bit)
    );

    pin_msg_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .line_in (pin_in),
        .result  (rx_res)
    );

    assign pin_dir      = dir_en;
    assign pin_out      = dir_en & tx_bit;
    assign rx_valid     = rx_res.valid;
    assign rx_word      = rx_res.word;
    assign rx_frame_err = rx_res.frame_err;

    // R5
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !send_busy |-> !pin_out);

endmodule

// File: tb/test_pin_msg_link.sv
`timescale 1ns/1ps
module test_pin_msg_link;
    localparam int NB = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        send_req = 1'b0;
    logic [31:0] send_word = '0;
    logic        send_busy, send_done;
    logic        dir_en = 1'b0;
    logic        pin_dir, pin_out;
    logic        ext_bit = 1'b0;
    logic        pin_in;
    logic        rx_valid, rx_frame_err;
    logic [31:0] rx_word;

    int tests = 0;
    int fails = 0;
    int vcnt = 0, ecnt = 0, dir_bad = 0;
    logic [31:0] vword = '0;

    always #2 clk = ~clk;

    assign pin_in = pin_dir ? pin_out : ext_bit;

    pin_msg_link #(.CLKS_PER_BIT(NB)) i_pin_msg_link (
        .clk(clk), .rst(rst), .send_req(send_req), .send_word(send_word),
        .send_busy(send_busy), .send_done(send_done), .dir_en(dir_en),
        .pin_dir(pin_dir), .pin_out(pin_out), .pin_in(pin_in),
        .rx_valid(rx_valid), .rx_word(rx_word), .rx_frame_err(rx_frame_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin vcnt++; vword = rx_word; end
            if (rx_frame_err) ecnt++;
            if (pin_dir !== dir_en) dir_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] frame_bits(input logic [31:0] w, input logic stop);
        return {3'b010, w, stop};
    endfunction

    task automatic drive_bit(input logic b);
        ext_bit = b;
        repeat (NB) @(negedge clk);
    endtask

    task automatic drive_frame(input logic [31:0] w, input logic stop);
        logic [35:0] f;
        f = frame_bits(w, stop);
        drive_bit(1'b0);
        drive_bit(1'b0);
        for (int i = 35; i >= 0; i--) drive_bit(f[i]);
        ext_bit = 1'b0;
        repeat (3 * NB) @(negedge clk);
    endtask

    // Send through the block; with dir_en high the word returns over the shared pin.
    task automatic send_one(input logic [31:0] w, input bit poke);
        int n;
        int v0;
        bit early;
        logic [31:0] other;
        v0 = vcnt;
        early = 1'b0;
        other = ~w;
        @(negedge clk);
        send_word = w;
        send_req  = 1'b1;
        @(negedge clk);
        send_req  = 1'b0;
        send_word = '0;
        chk(send_busy == 1'b1, "R3 busy after accept", {31'd0, send_busy}, 32'd1);
        n = 1;
        while (send_busy) begin
            @(negedge clk);
            if (poke && n == 20) begin send_req = 1'b1; send_word = other; end
            if (poke && n == 21) begin send_req = 1'b0; send_word = '0; end
            if (!dir_en && pin_out) early = 1'b1;
            if (send_busy) begin
                n++;
                if (rx_valid) early = 1'b1;
            end
        end
        chk(n >= 35 * NB + 1 && n <= 36 * NB, "R3 busy length", n, 36 * NB);
        chk(send_done == 1'b1, "R3 done pulse", {31'd0, send_done}, 32'd1);
        if (dir_en) begin
            chk(rx_valid == 1'b1 && rx_word == w && !early, "R1 R7 loopback word", rx_word, w);
        end else begin
            chk(!early, "R5 pin_out quiet with dir_en low", {31'd0, early}, 32'd0);
        end
        @(negedge clk);
        chk(!send_done && !send_busy, "R4 R3 no extra frame",
            {30'd0, send_done, send_busy}, 32'd0);
        chk(!rx_valid && rx_word == 0, "R7 strobe one clock", rx_word, 32'd0);
        repeat (4 * NB) @(negedge clk);
        chk(vcnt == v0 + (dir_en ? 1 : 0), "R4 R5 frame count", vcnt - v0, dir_en ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int e0, v0;
        logic [31:0] w;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk({send_busy, send_done, pin_out, rx_valid, rx_frame_err} == 5'b0 && rx_word == 0,
            "R9 reset state", {27'd0, send_busy, send_done, pin_out, rx_valid, rx_frame_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({send_busy, send_done, pin_out, rx_valid, rx_frame_err} == 5'b0,
            "R9 after reset", {27'd0, send_busy, send_done, pin_out, rx_valid, rx_frame_err}, 32'd0);
        repeat (2 * NB) @(negedge clk);

        // R1 R2 R3 directed corners, then random words with varied idle gaps.
        dir_en = 1'b1;
        send_one(32'h0000_0000, 1'b0);
        send_one(32'hFFFF_FFFF, 1'b0);
        send_one(32'h8000_0001, 1'b0);
        for (int k = 0; k < 8; k++) begin
            repeat ($urandom_range(0, 5)) @(negedge clk);
            send_one($urandom, 1'b0);
        end

        // R4 request raised mid-frame is ignored.
        send_one(32'hA5A5_0F0F, 1'b1);

        // R5 send with dir_en low: nothing on the pad, send still finishes.
        dir_en = 1'b0;
        send_one(32'h1234_5678, 1'b0);

        // R1 MSB-first order, driven from outside.
        v0 = vcnt;
        drive_frame(32'h8000_0000, 1'b0);
        chk(vcnt == v0 + 1 && vword == 32'h8000_0000, "R1 MSB first", vword, 32'h8000_0000);
        for (int k = 0; k < 4; k++) begin
            w = $urandom;
            v0 = vcnt;
            drive_frame(w, 1'b0);
            chk(vcnt == v0 + 1 && vword == w, "R2 external random frame", vword, w);
        end

        // R8 bad stop bit, then recovery.
        v0 = vcnt; e0 = ecnt;
        drive_frame(32'hDEAD_BEEF, 1'b1);
        chk(ecnt == e0 + 1, "R8 frame error pulse", ecnt - e0, 32'd1);
        chk(vcnt == v0, "R8 no word on bad stop", vcnt - v0, 32'd0);
        drive_frame(32'h0BAD_F00D, 1'b0);
        chk(vcnt == v0 + 1 && vword == 32'h0BAD_F00D, "R8 recovers", vword, 32'h0BAD_F00D);

        // R6 false start 0,1,1 rejected, then a good frame.
        v0 = vcnt;
        drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1);
        chk(vcnt == v0, "R6 false start ignored", vcnt - v0, 32'd0);
        drive_frame(32'h3C3C_C3C3, 1'b0);
        chk(vcnt == v0 + 1 && vword == 32'h3C3C_C3C3, "R6 resync after false start",
            vword, 32'h3C3C_C3C3);

        // R6 line held high before the frame: no match without an idle 0 first.
        v0 = vcnt;
        repeat (4) drive_bit(1'b1);
        drive_bit(1'b0);
        chk(vcnt == v0 && ecnt == e0 + 1, "R6 steady high ignored", vcnt - v0, 32'd0);

        chk(dir_bad == 0, "R5 pin_dir follows dir_en", dir_bad, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule